// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator

This block turns a 14-bit virtual address into a 12-bit physical address for a requester that works in 64-byte pages. The upper 8 bits form the virtual page number and the low 6 bits are the page offset. Recent translations are kept in a 16-entry translation buffer, arranged as 4 sets of 4 ways. A hit answers without touching memory. A miss reads one page-table word through a simple read port, checks it, installs it when it is usable, and then answers.

Each request carries an access kind (read, write or instruction fetch) and a privilege flag. The response returns either a physical address or a 2-bit fault code. The fault code separates a missing page from a permission violation. A flush input drops every buffered translation, for example after the page table has been rewritten.

Top module: `va_translator`

## Requirements
- R1: A successful response carries rsp_paddr = {PPN, vaddr[5:0]}: the page offset passes through unchanged and the 6-bit physical page number sits in bits 11:6.
- R2: The buffer set is vpn[1:0] and the tag is vpn[7:2]. A hit makes no memory read, and rsp_valid is high one clock edge after the edge that accepted the request.
- R3: A miss makes exactly one memory read, at address pt_base + 2*vpn. With mem_ack returned in the same cycle as mem_req, rsp_valid is high two edges after the accepting edge. mem_req and mem_addr hold until mem_ack.
- R4: A page-table word is decoded as follows: bit 0 valid, bit 1 privileged-only, bit 2 write allowed, bit 3 fetch allowed, bits 9:4 physical page number.
- R5: A fetched word with bit 0 clear gives rsp_fault = 01 (page fault) with rsp_paddr = 0. A page fault takes precedence over any permission check.
- R6: rsp_fault = 10 (protection fault) with rsp_paddr = 0 is returned when any of these holds: the privileged-only bit is set and req_priv is 0; req_kind is 01 (write) and the write bit is clear; req_kind is 10 (fetch) and the fetch bit is clear. req_kind 00 (and 11) is a read. The check applies to hits and to misses alike.
- R7: A fetched word that faults for the current access is not installed, so the next request to that page reads memory again.
- R8: A refill goes to the indexed set and takes the lowest-numbered empty way. When the set is full, it takes the way named by that set's 2-bit round-robin pointer, which then advances by one. The pointers restart at way 0 after reset or flush.
- R9: A one-cycle flush pulse empties the whole buffer, so the next request to any page misses.
- R10: req_ready is high only while no request is in flight. A response stays valid with stable address and fault until rsp_ready, and rsp_fault is never 11.
- R11: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all buffered translations |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 12 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| pt_base | input | 16 | Page-table base address |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | 16 | Page-table word address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Page-table word |

## Verification
A hit must raise rsp_valid exactly one edge after the accepting edge, and a miss exactly two when memory acknowledges in the same cycle. The bench therefore counts clock edges from acceptance until rsp_valid rises and compares that count with the one implied by the number of memory reads expected. All outputs are sampled on the falling edge. Read counts come from a monitor that tallies acknowledged reads, so every buffer hit, miss, refill and eviction is visible at the ports as a count of zero or one per request.

// File: rtl/vat_pkg.sv
package vat_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } flt_t;

  typedef struct packed {
    logic sup;
    logic wr;
    logic ex;
  } perm_t;

  localparam int PTE_V_BIT   = 0;
  localparam int PTE_SUP_BIT = 1;
  localparam int PTE_WR_BIT  = 2;
  localparam int PTE_EX_BIT  = 3;
  localparam int PTE_PPN_LSB = 4;
endpackage

// File: rtl/vat_perm.sv
module vat_perm
  import vat_pkg::*;
(
  input  perm_t perm,
  input  acc_t  kind,
  input  logic  priv,
  output logic  deny
);
  always_comb begin
    deny = 1'b0;
    if (perm.sup && !priv)                deny = 1'b1;
    if ((kind == ACC_WRITE) && !perm.wr)  deny = 1'b1;
    if ((kind == ACC_FETCH) && !perm.ex)  deny = 1'b1;
  end
endmodule

// File: rtl/vat_tlb.sv
module vat_tlb
  import vat_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output perm_t            hit_perm,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  perm_t            fill_perm
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];
  logic [WAY_W-1:0] rr_d  [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  perm_t            perm_q[SETS][WAYS];

  logic             has_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] victim;

  // lookup across the ways of one set
  always_comb begin
    hit      = 1'b0;
    hit_ppn  = '0;
    hit_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)) begin
        hit      = 1'b1;
        hit_ppn  = ppn_q[lk_set][w];
        hit_perm = perm_q[lk_set][w];
      end
    end
  end

  // victim: lowest empty way, else the set's rotating pointer
  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[fill_set][w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    victim = has_free ? free_way : rr_q[fill_set];
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_d[s] = '0;
        rr_d[s]  = '0;
      end
    end else if (fill_en) begin
      vld_d[fill_set][victim] = 1'b1;
      if (!has_free) rr_d[fill_set] = rr_q[fill_set] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[fill_set][victim]  <= fill_tag;
      ppn_q[fill_set][victim]  <= fill_ppn;
      perm_q[fill_set][victim] <= fill_perm;
    end
  end
endmodule

// File: rtl/va_translator.sv
module va_translator
  import vat_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int MA_W  = 16,
  parameter int PTE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_priv,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  input  logic [MA_W-1:0]  pt_base,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - SET_W;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WALK, S_RESP} st_t;

  st_t             st_q, st_d;
  logic [VA_W-1:0] va_q;
  acc_t            kind_q;
  logic            priv_q;
  logic [PA_W-1:0] pa_q, pa_d;
  flt_t            flt_q, flt_d;
  logic            acc_en, res_en, fill_en;

  logic [VPN_W-1:0] vpn;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             hit, deny;
  logic [PPN_W-1:0] hit_ppn, pte_ppn;
  perm_t            hit_perm, pte_perm, perm_sel;
  logic             pte_valid;
  logic             unused_hi;

  assign vpn     = va_q[VA_W-1:OFF_W];
  assign set_idx = vpn[SET_W-1:0];
  assign tag     = vpn[VPN_W-1:SET_W];

  assign pte_valid    = mem_rdata[PTE_V_BIT];
  assign pte_perm.sup = mem_rdata[PTE_SUP_BIT];
  assign pte_perm.wr  = mem_rdata[PTE_WR_BIT];
  assign pte_perm.ex  = mem_rdata[PTE_EX_BIT];
  assign pte_ppn      = mem_rdata[PTE_PPN_LSB +: PPN_W];
  assign unused_hi    = ^mem_rdata[PTE_W-1:PTE_PPN_LSB+PPN_W];

  assign perm_sel = (st_q == S_WALK) ? pte_perm : hit_perm;

  vat_tlb #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_set    (set_idx),
    .lk_tag    (tag),
    .hit       (hit),
    .hit_ppn   (hit_ppn),
    .hit_perm  (hit_perm),
    .fill_en   (fill_en),
    .fill_set  (set_idx),
    .fill_tag  (tag),
    .fill_ppn  (pte_ppn),
    .fill_perm (pte_perm)
  );

  vat_perm u_perm (
    .perm (perm_sel),
    .kind (kind_q),
    .priv (priv_q),
    .deny (deny)
  );

  always_comb begin
    st_d    = st_q;
    pa_d    = pa_q;
    flt_d   = flt_q;
    acc_en  = 1'b0;
    res_en  = 1'b0;
    fill_en = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          acc_en = 1'b1;
          st_d   = S_LOOK;
        end
      end
      S_LOOK: begin
        if (hit) begin
          res_en = 1'b1;
          st_d   = S_RESP;
          if (deny) begin
            flt_d = FLT_PROT;
            pa_d  = '0;
          end else begin
            flt_d = FLT_NONE;
            pa_d  = {hit_ppn, va_q[OFF_W-1:0]};
          end
        end else begin
          st_d = S_WALK;
        end
      end
      S_WALK: begin
        if (mem_ack) begin
          res_en = 1'b1;
          st_d   = S_RESP;
          if (!pte_valid) begin
            flt_d = FLT_PAGE;
            pa_d  = '0;
          end else if (deny) begin
            flt_d = FLT_PROT;
            pa_d  = '0;
          end else begin
            flt_d   = FLT_NONE;
            pa_d    = {pte_ppn, va_q[OFF_W-1:0]};
            fill_en = 1'b1;
          end
        end
      end
      default: begin
        if (rsp_ready) st_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      pa_q  <= '0;
      flt_q <= FLT_NONE;
    end else begin
      st_q <= st_d;
      if (res_en) begin
        pa_q  <= pa_d;
        flt_q <= flt_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en) begin
      va_q   <= req_vaddr;
      kind_q <= acc_t'(req_kind);
      priv_q <= req_priv;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RESP);
  assign mem_req   = (st_q == S_WALK);
  assign mem_addr  = pt_base + MA_W'({vpn, 1'b0});
  assign rsp_paddr = pa_q;
  assign rsp_fault = flt_q;
endmodule

// File: rtl/vat_chk.sv
module vat_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int MA_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_fault,
  input logic [MA_W-1:0]  pt_base,
  input logic             mem_req,
  input logic [MA_W-1:0]  mem_addr,
  input logic             mem_ack
);
  localparam int VPN_W = VA_W - OFF_W;

  logic [OFF_W-1:0] off_cap;
  logic [VPN_W-1:0] vpn_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cap <= '0;
      vpn_cap <= '0;
    end else if (req_valid && req_ready) begin
      off_cap <= req_vaddr[OFF_W-1:0];
      vpn_cap <= req_vaddr[VA_W-1:OFF_W];
    end
  end

  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == 2'b00) |-> rsp_paddr[OFF_W-1:0] == off_cap)
    else $error("offset not passed through");

  p_walk_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr == pt_base + MA_W'({vpn_cap, 1'b0}))
    else $error("wrong table address");

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr))
    else $error("read request dropped");

  p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'b00) |-> rsp_paddr == '0)
    else $error("address on fault");

  p_fault_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11)
    else $error("illegal fault code");

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))
    else $error("response changed while stalled");

  p_one_inflight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req) |-> !req_ready)
    else $error("accepting while busy");
endmodule

bind va_translator vat_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .MA_W(MA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .pt_base   (pt_base),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/sim_va_translator.sv
`timescale 1ns/1ps
module sim_va_translator;
  localparam logic [15:0] BASE = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n, flush, req_valid, req_ready, req_priv;
  logic [13:0] req_vaddr;
  logic [1:0]  req_kind, rsp_fault;
  logic        rsp_valid, rsp_ready, mem_req, mem_ack;
  logic [11:0] rsp_paddr;
  logic [15:0] pt_base, mem_addr, mem_rdata;

  logic [15:0] ptmem [256];
  int checks = 0;
  int errs = 0;
  int rd_cnt = 0;
  logic [15:0] last_addr = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  va_translator u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .pt_base(pt_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // page-table memory answering in the same cycle
  assign mem_ack   = mem_req;
  assign mem_rdata = ptmem[8'((mem_addr - BASE) >> 1)];

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      rd_cnt++;
      last_addr = mem_addr;
    end
  end

  function automatic logic [15:0] mk_pte(bit v, bit s, bit w, bit x, logic [5:0] ppn);
    return {6'b0, ppn, x, w, s, v};
  endfunction

  function automatic logic [11:0] def_pa(logic [7:0] vpn, logic [5:0] off);
    return {vpn[5:0] ^ 6'h15, off};
  endfunction

  // {vaddr14, kind2, priv1, exp_paddr12, exp_fault2, exp_reads1}
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {14'h03D4, 2'd0, 1'b0, 12'h354, 2'b00, 1'b1},  // R1 R2 R3: miss, install
    {14'h03D4, 2'd1, 1'b0, 12'h354, 2'b00, 1'b0},  // R2: hit
    {14'h0B8F, 2'd0, 1'b0, 12'h000, 2'b01, 1'b1},  // R5: invalid entry
    {14'h0B8F, 2'd0, 1'b1, 12'h000, 2'b01, 1'b1},  // R5 R7: not installed
    {14'h00E1, 2'd0, 1'b0, 12'h000, 2'b10, 1'b1},  // R6: privileged-only page
    {14'h00E1, 2'd0, 1'b1, 12'h0A1, 2'b00, 1'b1},  // R7 R4: refetched, now ok
    {14'h00E1, 2'd1, 1'b0, 12'h000, 2'b10, 1'b0},  // R6: check on a hit
    {14'h017F, 2'd2, 1'b0, 12'h5BF, 2'b00, 1'b1},  // R4: fetch bit honoured
    {14'h017F, 2'd1, 1'b0, 12'h000, 2'b10, 1'b0},  // R6: read-only page write
    {14'h0400, 2'd1, 1'b0, 12'h140, 2'b00, 1'b1},  // R1: default entry
    {14'h0400, 2'd2, 1'b0, 12'h000, 2'b10, 1'b0}   // R6: no fetch bit
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1 vec0";  1: return "R2 vec1";  2: return "R5 vec2";
      3: return "R7 vec3";  4: return "R6 vec4";  5: return "R4 vec5";
      6: return "R6 vec6";  7: return "R4 vec7";  8: return "R6 vec8";
      9: return "R1 vec9";  default: return "R6 vec10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [13:0] va, input logic [1:0] kind, input bit priv,
                       input logic [11:0] epa, input logic [1:0] eflt, input int erd,
                       input int hold, input string req);
    int r0;
    int n;
    logic [11:0] pa_s;
    logic [1:0]  f_s;
    @(negedge clk);
    chk(req_ready == 1'b1, req, "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_priv = priv;
    r0 = rd_cnt;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 20) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
    chk(n == 1 + erd, req, "edges to response", n, 1 + erd);
    chk(rsp_paddr == epa, req, "paddr", int'(rsp_paddr), int'(epa));
    chk(rsp_fault == eflt, req, "fault", int'(rsp_fault), int'(eflt));
    chk(rd_cnt - r0 == erd, req, "memory reads", rd_cnt - r0, erd);
    pa_s = rsp_paddr;
    f_s  = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_paddr == pa_s && rsp_fault == f_s,
          "R10", "response held", int'(rsp_paddr), int'(pa_s));
    end
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, req, "response released", int'(rsp_valid), 0);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
    req_vaddr = '0; req_kind = '0; req_priv = 1'b0; pt_base = BASE;
    for (int i = 0; i < 256; i++) ptmem[i] = mk_pte(1, 0, 1, 0, 6'(i) ^ 6'h15);
    ptmem[8'h0F] = mk_pte(1, 0, 1, 0, 6'h0D);
    ptmem[8'h2E] = mk_pte(0, 0, 1, 1, 6'h3F);
    ptmem[8'h03] = mk_pte(1, 1, 1, 0, 6'h02);
    ptmem[8'h05] = mk_pte(1, 0, 0, 1, 6'h16);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid", int'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R11", "mem_req", int'(mem_req), 0);

    for (int i = 0; i < NV; i++) begin
      xlate(VEC[i][31:18], VEC[i][17:16], VEC[i][15], VEC[i][14:3], VEC[i][2:1],
            int'(VEC[i][0]), 0, vec_tag(i));
    end

    // R9: flush empties the buffer; R3: table address on the refetch
    xlate(14'h03D4, 2'd0, 1'b0, 12'h354, 2'b00, 0, 0, "R9 before flush");
    pulse_flush();
    xlate(14'h03D4, 2'd0, 1'b0, 12'h354, 2'b00, 1, 0, "R9 after flush");
    chk(last_addr == BASE + 16'h001E, "R3", "table address", int'(last_addr), int'(BASE + 16'h001E));

    // R8: fill set 0, then evict by round-robin
    pulse_flush();
    xlate({8'h00, 6'h01}, 2'd0, 1'b0, def_pa(8'h00, 6'h01), 2'b00, 1, 0, "R8 fill w0");
    xlate({8'h04, 6'h02}, 2'd0, 1'b0, def_pa(8'h04, 6'h02), 2'b00, 1, 0, "R8 fill w1");
    xlate({8'h08, 6'h03}, 2'd0, 1'b0, def_pa(8'h08, 6'h03), 2'b00, 1, 0, "R8 fill w2");
    xlate({8'h0C, 6'h04}, 2'd0, 1'b0, def_pa(8'h0C, 6'h04), 2'b00, 1, 0, "R8 fill w3");
    xlate({8'h00, 6'h05}, 2'd0, 1'b0, def_pa(8'h00, 6'h05), 2'b00, 0, 0, "R8 full set hit");
    xlate({8'h14, 6'h06}, 2'd0, 1'b0, def_pa(8'h14, 6'h06), 2'b00, 1, 0, "R8 evict w0");
    xlate({8'h04, 6'h07}, 2'd0, 1'b0, def_pa(8'h04, 6'h07), 2'b00, 0, 0, "R8 w1 kept");
    xlate({8'h00, 6'h08}, 2'd0, 1'b0, def_pa(8'h00, 6'h08), 2'b00, 1, 0, "R8 evicted page");
    xlate({8'h08, 6'h09}, 2'd0, 1'b0, def_pa(8'h08, 6'h09), 2'b00, 0, 0, "R8 w2 kept");
    xlate({8'h04, 6'h0A}, 2'd0, 1'b0, def_pa(8'h04, 6'h0A), 2'b00, 1, 0, "R8 w1 evicted");
    xlate({8'h05, 6'h0B}, 2'd0, 1'b0, 12'h58B, 2'b00, 1, 0, "R2 other set miss");

    // R10: stalled response stays put
    xlate({8'h14, 6'h3F}, 2'd1, 1'b0, def_pa(8'h14, 6'h3F), 2'b00, 0, 3, "R10 stall");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule